// File: doc/BRIEF.md
# Interrupt Source Coalescing State Array

This block keeps a two-bit record for each of a parameterised number of interrupt sources. The first bit, P, says that an event for the source has been handed to the downstream queue and is waiting for end-of-interrupt. The second bit, Q, says that a further trigger arrived while P was set. A trigger on a source with no outstanding event forwards the source index downstream. Triggers that land while an event is outstanding are folded into Q. End-of-interrupt then re-fires the source if Q is set. As a result, normal operation never places the same source in the queue twice.

Software reaches the array through a register port. A source index and a 12-bit page offset select one atomic read-modify-write: end-of-interrupt by load or by store, a plain state read, or a load that forces the state to one of the four codes. Every load returns the state from before its own update. Hardware triggers arrive as one strobe per source per cycle.

Forward requests are held in a pending bit per source until the event output takes them. The event output is a valid/ready handshake that carries the source index.

Top module: `irq_coalesce_array`

## Requirements
- R1: After reset every source is in state P=0,Q=0. Neither an event nor a response is presented.
- R2: A trigger moves a source as follows: 00 goes to 10 and forwards one event; 10 goes to 11 with no event; 11 stays 11; 01 (masked) stays 01 with no event.
- R3: A load at offset 0x000 performs end-of-interrupt. It returns the old state and clears P and Q. If the old Q was 1, the source goes to 10 and forwards an event in the same operation.
- R4: A store at offset 0x400 makes the same state change as R3 and produces no response.
- R5: A load at offset 0x800 returns the state and leaves it unchanged.
- R6: Loads at 0xC00, 0xD00, 0xE00 and 0xF00 return the old state and set the state to 00, 01, 10 and 11 (bits 9:8 of the offset). They forward no event.
- R7: The response to an accepted load appears in the following cycle, and only then. Bit 1 of the response data is P, bit 0 is Q, and bits 63:2 are zero. The port accepts one operation every cycle.
- R8: A load with a source index of NUM_SRC or more, or with an undefined offset, returns 0xFF and changes no state. A store at any offset other than 0x400, or to an out-of-range index, has no effect.
- R9: Adding 0x040 to a load offset gives the same operation. Every store takes effect in the cycle it is accepted, so any later load observes it.
- R10: While the event output is valid and not ready, it holds its source index. No forwarded event is lost. When several are waiting, the lowest source index goes out first.
- R11: When a register operation and a trigger hit the same source in the same cycle, the register operation is applied first. The trigger then acts on the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | NUM_SRC | One trigger strobe per source |
| reg_valid | input | 1 | Register operation request |
| reg_ready | output | 1 | Operation accepted (always high) |
| reg_write | input | 1 | 1 = store, 0 = load |
| reg_src | input | IDXW | Source index |
| reg_offset | input | 12 | Operation offset inside the source page |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 64 | Old state code or 0xFF |
| evt_valid | output | 1 | Event toward the queue |
| evt_ready | input | 1 | Queue accepts the event |
| evt_src | output | IDXW | Source index of the event |

## Verification
Some properties are checked on every cycle. The event index must stay stable while the output is stalled and must always be in range. A response must follow each accepted load exactly one cycle later, and at no other time. Response data above the state code must be zero, and an out-of-range index must answer 0xFF. Other behaviour is only visible through the bench's scenarios and its behavioural model: the per-state trigger and end-of-interrupt transitions, the forced-state loads, the ordering-offset alias, the lowest-index drain order, and the same-cycle collision order.

// File: rtl/irq_pq_pkg.sv
package irq_pq_pkg;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EOI,
        OP_GET,
        OP_SET,
        OP_BAD
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        pq_t      set_val;
    } op_t;

    typedef struct packed {
        pq_t  nxt;
        logic fire;
    } step_t;

    localparam logic [11:0] OFS_LD_EOI = 12'h000;
    localparam logic [11:0] OFS_ST_EOI = 12'h400;
    localparam logic [11:0] OFS_GET    = 12'h800;
    localparam logic [11:0] OFS_ORDER  = 12'h040;
    localparam logic [7:0]  BAD_CODE   = 8'hFF;

    function automatic op_t decode_op(input logic wr, input logic [11:0] ofs);
        op_t         r;
        logic [11:0] base;
        r.kind    = OP_BAD;
        r.set_val = '0;
        base      = ofs & ~OFS_ORDER;
        if (wr) begin
            if (ofs == OFS_ST_EOI) r.kind = OP_EOI;
        end else if (base == OFS_LD_EOI) begin
            r.kind = OP_EOI;
        end else if (base == OFS_GET) begin
            r.kind = OP_GET;
        end else if (base[11:10] == 2'b11 && base[7:0] == 8'h00) begin
            r.kind    = OP_SET;
            r.set_val = base[9:8];
        end
        return r;
    endfunction

    function automatic step_t trigger_step(input pq_t s);
        step_t r;
        r.nxt  = s;
        r.fire = 1'b0;
        case ({s.p, s.q})
            2'b00: begin r.nxt = 2'b10; r.fire = 1'b1; end
            2'b10: r.nxt = 2'b11;
            default: r.nxt = s;
        endcase
        return r;
    endfunction

    function automatic step_t eoi_step(input pq_t s);
        step_t r;
        r.nxt  = s.q ? 2'b10 : 2'b00;
        r.fire = s.q;
        return r;
    endfunction

endpackage

// File: rtl/irq_op_decode.sv
module irq_op_decode
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDXW    = $clog2(NUM_SRC)
) (
    input  logic               reg_valid,
    input  logic               reg_write,
    input  logic [IDXW-1:0]    reg_src,
    input  logic [11:0]        reg_offset,
    output op_t                op,
    output logic [NUM_SRC-1:0] sel,
    output logic               load_bad
);
    localparam logic [IDXW:0] SRC_LIMIT = (IDXW+1)'(NUM_SRC);

    logic in_range;
    logic changes_state;

    always_comb begin
        in_range      = {1'b0, reg_src} < SRC_LIMIT;
        op            = decode_op(reg_write, reg_offset);
        changes_state = (op.kind == OP_EOI) || (op.kind == OP_SET);
        load_bad      = !reg_write && (!in_range || op.kind == OP_BAD);
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
            assign sel[i] = reg_valid && in_range && changes_state &&
                            (reg_src == IDXW'(i));
        end
    endgenerate

endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_pq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  op_t  op,
    input  logic trig,
    output pq_t  state,
    output logic fire
);
    pq_t   after_op;
    pq_t   after_trig;
    logic  op_fire;
    step_t eoi_r;
    step_t trig_r;

    always_comb begin
        after_op = state;
        op_fire  = 1'b0;
        eoi_r    = eoi_step(state);
        if (sel) begin
            case (op.kind)
                OP_EOI: begin
                    after_op = eoi_r.nxt;
                    op_fire  = eoi_r.fire;
                end
                OP_SET: after_op = op.set_val;
                default: after_op = state;
            endcase
        end
        trig_r     = trigger_step(after_op);
        after_trig = trig ? trig_r.nxt : after_op;
        fire       = op_fire | (trig & trig_r.fire);
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= after_trig;
    end

endmodule

// File: rtl/irq_evt_queue.sv
module irq_evt_queue #(
    parameter int NUM_SRC = 12,
    parameter int IDXW    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] fire,
    input  logic               evt_ready,
    output logic               evt_valid,
    output logic [IDXW-1:0]    evt_src
);
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] pend_all;
    logic [NUM_SRC-1:0] pick_mask;
    logic [IDXW-1:0]    pick_idx;
    logic               found;
    logic               load_out;

    always_comb begin
        pend_all  = pend_q | fire;
        load_out  = !evt_valid || evt_ready;
        found     = 1'b0;
        pick_idx  = '0;
        pick_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!found && pend_all[i]) begin
                found        = 1'b1;
                pick_idx     = IDXW'(i);
                pick_mask[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            evt_valid <= 1'b0;
            evt_src   <= '0;
        end else if (load_out) begin
            evt_valid <= found;
            if (found) evt_src <= pick_idx;
            pend_q    <= pend_all & ~pick_mask;
        end else begin
            pend_q    <= pend_all;
        end
    end

endmodule

// File: rtl/irq_coalesce_array.sv
module irq_coalesce_array
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int IDXW    = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] trig_in,
    input  logic               reg_valid,
    output logic               reg_ready,
    input  logic               reg_write,
    input  logic [IDXW-1:0]    reg_src,
    input  logic [11:0]        reg_offset,
    output logic               rsp_valid,
    output logic [63:0]        rsp_data,
    output logic               evt_valid,
    input  logic               evt_ready,
    output logic [IDXW-1:0]    evt_src
);
    op_t                op;
    logic [NUM_SRC-1:0] sel;
    logic               load_bad;
    logic [NUM_SRC-1:0] fire;
    pq_t                cur_state [NUM_SRC];
    pq_t                old_state;

    assign reg_ready = 1'b1;

    irq_op_decode #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_dec (
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_src   (reg_src),
        .reg_offset(reg_offset),
        .op        (op),
        .sel       (sel),
        .load_bad  (load_bad)
    );

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
            irq_src_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .sel  (sel[i]),
                .op   (op),
                .trig (trig_in[i]),
                .state(cur_state[i]),
                .fire (fire[i])
            );
        end
    endgenerate

    irq_evt_queue #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .evt_ready(evt_ready),
        .evt_valid(evt_valid),
        .evt_src  (evt_src)
    );

    always_comb begin
        old_state = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (reg_src == IDXW'(i)) old_state = cur_state[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= reg_valid && reg_ready && !reg_write;
            if (reg_valid && reg_ready && !reg_write)
                rsp_data <= {56'd0, load_bad ? BAD_CODE : {6'd0, old_state}};
        end
    end

endmodule

// File: rtl/irq_coalesce_array_chk.sv
module irq_coalesce_array_chk #(
    parameter int NUM_SRC = 12,
    parameter int IDXW    = $clog2(NUM_SRC)
) (
    input logic            clk,
    input logic            rst,
    input logic            reg_valid,
    input logic            reg_ready,
    input logic            reg_write,
    input logic [IDXW-1:0] reg_src,
    input logic            rsp_valid,
    input logic [63:0]     rsp_data,
    input logic            evt_valid,
    input logic            evt_ready,
    input logic [IDXW-1:0] evt_src
);
    localparam logic [IDXW:0] SRC_LIMIT = (IDXW+1)'(NUM_SRC);

    logic load_acc;
    assign load_acc = reg_valid && reg_ready && !reg_write;

    assert_evt_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_src)));

    assert_evt_range_R10: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> ({1'b0, evt_src} < SRC_LIMIT));

    assert_rsp_after_load_R7: assert property (@(posedge clk) disable iff (rst)
        load_acc |=> rsp_valid);

    assert_no_stray_rsp_R7: assert property (@(posedge clk) disable iff (rst)
        !load_acc |=> !rsp_valid);

    assert_rsp_upper_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_data[7:0] != 8'hFF) |-> (rsp_data[63:2] == '0));

    assert_bad_index_R8: assert property (@(posedge clk) disable iff (rst)
        (load_acc && ({1'b0, reg_src} >= SRC_LIMIT)) |=> (rsp_data == 64'hFF));

endmodule

bind irq_coalesce_array irq_coalesce_array_chk #(.NUM_SRC(NUM_SRC), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_valid(reg_valid),
    .reg_ready(reg_ready),
    .reg_write(reg_write),
    .reg_src  (reg_src),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .evt_valid(evt_valid),
    .evt_ready(evt_ready),
    .evt_src  (evt_src)
);

// File: tb/irq_coalesce_array_test.sv
`timescale 1ns/1ps
module irq_coalesce_array_test;
    localparam int N    = 12;
    localparam int IDXW = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    trig_in = '0;
    logic            reg_valid = 1'b0;
    logic            reg_ready;
    logic            reg_write = 1'b0;
    logic [IDXW-1:0] reg_src = '0;
    logic [11:0]     reg_offset = '0;
    logic            rsp_valid;
    logic [63:0]     rsp_data;
    logic            evt_valid;
    logic            evt_ready = 1'b1;
    logic [IDXW-1:0] evt_src;

    always #10 clk = ~clk;

    irq_coalesce_array #(.NUM_SRC(N), .IDXW(IDXW)) uut (
        .clk(clk), .rst(rst), .trig_in(trig_in),
        .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_write(reg_write),
        .reg_src(reg_src), .reg_offset(reg_offset),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_src(evt_src)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";

    int m_st   [N];
    bit m_pend [N];
    bit m_ov;
    int m_os;
    bit e_rv;
    int e_rd;

    task automatic check(input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic do_eoi(input int i);
        if (m_st[i] % 2 == 1) begin m_st[i] = 2; m_pend[i] = 1; end
        else m_st[i] = 0;
    endtask

    task automatic model_eval();
        int idx, base;
        bit ok;
        idx  = int'(reg_src);
        ok   = idx < N;
        base = int'(reg_offset) & ~32'h40;
        e_rv = reg_valid && !reg_write;
        if (reg_valid && !reg_write) begin
            e_rd = 8'hFF;
            if (ok && base == 12'h000) begin e_rd = m_st[idx]; do_eoi(idx); end
            else if (ok && base == 12'h800) e_rd = m_st[idx];
            else if (ok && (base == 12'hC00 || base == 12'hD00 ||
                            base == 12'hE00 || base == 12'hF00)) begin
                e_rd = m_st[idx];
                m_st[idx] = (base >> 8) & 3;
            end
        end
        if (reg_valid && reg_write && ok && reg_offset == 12'h400) do_eoi(idx);
        for (int i = 0; i < N; i++) begin
            if (trig_in[i]) begin
                if (m_st[i] == 0) begin m_st[i] = 2; m_pend[i] = 1; end
                else if (m_st[i] == 2) m_st[i] = 3;
            end
        end
        if (!m_ov || evt_ready) begin
            m_ov = 0;
            for (int i = 0; i < N; i++) begin
                if (!m_ov && m_pend[i]) begin m_ov = 1; m_os = i; m_pend[i] = 0; end
            end
        end
    endtask

    task automatic compare();
        check("evt_valid", longint'(evt_valid), longint'(m_ov));
        if (m_ov) check("evt_src", longint'(evt_src), longint'(m_os));
        check("rsp_valid", longint'(rsp_valid), longint'(e_rv));
        if (e_rv) check("rsp_data", longint'(rsp_data), longint'(e_rd));
    endtask

    task automatic cycle();
        model_eval();
        @(posedge clk);
        @(negedge clk);
        compare();
        reg_valid = 1'b0;
        reg_write = 1'b0;
        trig_in   = '0;
    endtask

    task automatic load(input int src, input int ofs);
        reg_valid = 1'b1; reg_write = 1'b0;
        reg_src = IDXW'(src); reg_offset = 12'(ofs);
        cycle();
    endtask

    task automatic store(input int src, input int ofs);
        reg_valid = 1'b1; reg_write = 1'b1;
        reg_src = IDXW'(src); reg_offset = 12'(ofs);
        cycle();
    endtask

    task automatic trig(input int src);
        trig_in[src] = 1'b1;
        cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_st[i] = 0; m_pend[i] = 0; end
        m_ov = 0; m_os = 0; e_rv = 0; e_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        compare();
        check("reg_ready R7", longint'(reg_ready), 1);
        for (int i = 0; i < N; i++) load(i, 12'h800);

        cur_req = "R2";
        trig(3); trig(3); trig(3); load(3, 12'h800);
        cur_req = "R6"; load(5, 12'hD00);
        cur_req = "R2"; trig(5); load(5, 12'h800);

        cur_req = "R3";
        load(3, 12'h000); cycle(); load(3, 12'h000); load(3, 12'h800);

        cur_req = "R4";
        trig(4); store(4, 12'h400); load(4, 12'h800);
        trig(4); trig(4); store(4, 12'h400); cycle(); load(4, 12'h800);

        cur_req = "R5";
        load(4, 12'h800); load(4, 12'h800);

        cur_req = "R6";
        load(7, 12'hF00); load(7, 12'hE00); load(7, 12'hD00);
        load(7, 12'hC00); load(7, 12'h800);

        cur_req = "R8";
        load(12, 12'h800); load(15, 12'h000); load(4, 12'h400); load(4, 12'h900);
        store(4, 12'h800); store(4, 12'hC00); store(13, 12'h400); load(4, 12'h800);

        cur_req = "R9";
        trig(8); trig(8);
        load(8, 12'h840); load(8, 12'h040); cycle(); load(8, 12'hE40);
        store(8, 12'h400); load(8, 12'h840);

        cur_req = "R10";
        evt_ready = 1'b0;
        trig_in[9] = 1'b1; trig_in[2] = 1'b1; trig_in[6] = 1'b1; cycle();
        cycle(); trig(2); cycle();
        evt_ready = 1'b1;
        cycle(); cycle(); cycle(); cycle();
        load(2, 12'h000); load(6, 12'h000); load(9, 12'h000); cycle(); cycle();

        cur_req = "R11";
        load(1, 12'hF00);
        trig_in[1] = 1'b1; load(1, 12'h000);
        load(1, 12'h800);
        trig_in[1] = 1'b1; load(1, 12'hC00);
        cycle(); load(1, 12'h800);
        trig_in[1] = 1'b1; store(1, 12'h400);
        load(1, 12'h800);

        cur_req = "R10";
        for (int k = 0; k < 400; k++) begin
            int pick;
            evt_ready = ($urandom_range(0, 3) != 0);
            if ($urandom_range(0, 2) == 0) trig_in[$urandom_range(0, N-1)] = 1'b1;
            if ($urandom_range(0, 1) == 0) begin
                pick       = $urandom_range(0, 9);
                reg_valid  = 1'b1;
                reg_write  = (pick == 1);
                reg_src    = IDXW'($urandom_range(0, 15));
                case (pick)
                    0: reg_offset = 12'h000;
                    1: reg_offset = 12'h400;
                    2: reg_offset = 12'h800;
                    3: reg_offset = 12'hC00;
                    4: reg_offset = 12'hD00;
                    5: reg_offset = 12'hE00;
                    6: reg_offset = 12'hF00;
                    7: reg_offset = 12'h040;
                    8: reg_offset = 12'h840;
                    default: reg_offset = 12'h123;
                endcase
            end
            cycle();
        end
        evt_ready = 1'b1;
        repeat (N + 2) cycle();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule